// File: doc/BRIEF.md
# Configurable UART with FIFO status

This block is a serial port that sits on a simple word-addressed register bus. Software writes characters into a 16-entry transmit queue, and the block sends each one as an asynchronous frame on `txd`. Frames arriving on `rxd` are decoded and placed in a 16-entry receive queue, which software drains by reading a data register. A status word reports whether each queue is empty or full. Latched error flags, together with two live level conditions, drive a single maskable interrupt line.

The length of one serial bit is a raw count of core clock cycles in the configuration word. There is no fixed oversampling ratio. Software picks the cycle within each received bit at which the line is sampled. The recommended setting is half the bit count, with a floor of 7. A character can carry 5 to 8 data bits, sent least significant bit first. An optional parity bit follows the data, and then one or two stop bits.

Data moves inside the block as streams. Each queue takes pushes only while it is not full (valid/ready). The transmitter pulls the next character from its queue only when it is idle and enabled, so a full or disabled transmitter holds characters back in the queue. The serial receive line cannot be held off. A character that arrives while the receive queue is full is therefore dropped and flagged. The bus port never stalls. A transaction takes effect on the clock edge where `bus_sel` is high. Read data is combinational from `bus_addr`.

Top module: `cfg_uart`

## Requirements
- R1: After reset `txd` is 1 and `irq` is 0. The queue status word (word 6) reads 0x0A, meaning both queues are empty. The interrupt status word (word 11) reads 0x20, meaning only the live transmit-empty bit is set.
- R2: Configuration word 0 sets the bit length in cycles (bits 31:8) and the character length in bits 1:0 (0→5, 1→6, 2→7, 3→8 bits). A transmitted frame is one low start bit, then the data bits LSB first, each bit that many cycles long. Data bits above the character length are not sent.
- R3: Configuration bit 4 enables a parity bit after the last data bit. Bit 3 set selects even parity (parity bit = XOR of the data bits). Bit 3 clear selects odd parity (the inverse).
- R4: Configuration bit 2 selects two stop bits instead of one. In a back-to-back burst, the interval from one start edge to the next is (1 + data bits + parity bit + stop bits) × bit length cycles, with up to 2 cycles of slack.
- R5: Characters are sent only while bit 7 (global enable) and bit 5 (transmit enable) are both set. Until then they stay in the transmit queue. The receiver ignores the line unless bit 7 and bit 6 (receive enable) are both set.
- R6: The receiver samples each bit at the cycle offset held in word 2. A read of word 5 pops one received character into bits 7:0, with unused high bits zero.
- R7: After a falling edge, the receiver re-checks the line at the sample offset of the start bit. If the line is high again, it returns to idle and stores no character.
- R8: A received parity mismatch latches interrupt bit 2. A low stop bit latches interrupt bit 1. The character is still stored in both cases.
- R9: Each queue holds 16 characters in arrival order. Status word bit 3 means transmit empty, bit 2 transmit full, bit 1 receive empty and bit 0 receive full. A write to word 4 while the transmit queue is full is dropped and latches interrupt bit 0.
- R10: A character that completes while the receive queue is full is discarded and latches interrupt bit 3.
- R11: A read of word 5 while the receive queue is empty returns 0 and latches interrupt bit 4.
- R12: Writing 1 to a bit of word 9 clears that latched interrupt bit. `irq` is the OR of interrupt status bits ANDed with the enable mask in word 7.
- R13: Interrupt status bit 6 is high while the receive queue holds data. Bit 5 is high while the transmit queue is empty. Writes to word 9 do not affect these two bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of character length, parity mode and stop count, with the transmit line looped back to the receive line. An independent mid-bit decoder checks each frame, and the received character is read back and compared. A design that truncated or mis-ordered data bits, inverted a parity sense or miscounted stop bits would show wrong decoded bits or wrong frame spacing. It would also fail to round-trip a 5-bit character with clean high bits. The queue boundaries are driven directly: a 17th transmit write, a 17th received character and a read of an empty queue. A design that wrapped its pointers would lose order or corrupt the oldest entry, and one that miscounted would never raise the matching error flag. Hand-driven frames on the receive line cover a short low glitch, a wrong parity bit and a low stop bit. A receiver that trusted the first edge would store a phantom character. One that dropped bad frames would lose the character the requirements say is kept.

// File: rtl/cfg_uart_pkg.sv
package cfg_uart_pkg;
  localparam logic [3:0] W_CFG  = 4'd0;
  localparam logic [3:0] W_SAMP = 4'd2;
  localparam logic [3:0] W_TXD  = 4'd4;
  localparam logic [3:0] W_RXD  = 4'd5;
  localparam logic [3:0] W_STAT = 4'd6;
  localparam logic [3:0] W_IEN  = 4'd7;
  localparam logic [3:0] W_ICLR = 4'd9;
  localparam logic [3:0] W_ISTA = 4'd11;

  localparam int EV_TXOVR = 0;
  localparam int EV_SERR  = 1;
  localparam int EV_PERR  = 2;
  localparam int EV_RXOVR = 3;
  localparam int EV_RXUND = 4;
  localparam int N_EV     = 5;
  localparam int N_INT    = 7;
endpackage

// File: rtl/cfg_uart_fifo.sv
module cfg_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp;
  logic             push, pop;

  assign empty     = (wp == rp);
  assign full      = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = mem[rp[AW-1:0]];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= in_data;
  end

  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !pop) |=> full); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R9
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx #(
  parameter int DIV_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              two_stop,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;

  tx_st_t            st;
  logic [DIV_W-1:0]  cnt, div_m1;
  logic [2:0]        idx, last;
  logic [DATA_W-1:0] sh, mask, masked;
  logic              par, stop2, at_end;

  assign div_m1   = (div == '0) ? '0 : div - 1'b1;
  assign at_end   = (cnt >= div_m1);
  assign last     = 3'd4 + {1'b0, len};
  assign mask     = {DATA_W{1'b1}} >> (2'd3 - len);
  assign masked   = in_data & mask;
  assign in_ready = (st == T_IDLE) && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= T_IDLE; txd <= 1'b1; cnt <= '0; idx <= '0;
      sh <= '0; par <= 1'b0; stop2 <= 1'b0;
    end else if (st == T_IDLE) begin
      txd <= 1'b1;
      cnt <= '0;
      if (in_valid && in_ready) begin
        sh  <= masked;
        par <= par_even ? ^masked : ~^masked;
        txd <= 1'b0;
        st  <= T_START;
      end
    end else if (!at_end) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
      case (st)
        T_START: begin
          txd <= sh[0];
          idx <= '0;
          st  <= T_DATA;
        end
        T_DATA: begin
          if (idx == last) begin
            stop2 <= 1'b0;
            if (par_en) begin txd <= par;  st <= T_PAR;  end
            else        begin txd <= 1'b1; st <= T_STOP; end
          end else begin
            sh  <= sh >> 1;
            txd <= sh[1];
            idx <= idx + 3'd1;
          end
        end
        T_PAR: begin
          txd <= 1'b1;
          st  <= T_STOP;
        end
        T_STOP: begin
          if (two_stop && !stop2) stop2 <= 1'b1;
          else                    st    <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_START) |-> !txd); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_STOP) |-> txd); // R4
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx #(
  parameter int DIV_W  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              line,
  input  logic [DIV_W-1:0]  div,
  input  logic [DIV_W-1:0]  samp,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_even,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_serr
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_t;

  rx_st_t            st;
  logic [DIV_W-1:0]  cnt, div_m1;
  logic [2:0]        idx, last;
  logic [DATA_W-1:0] dat;
  logic              line_q, acc, perr, at_samp, at_end;

  assign div_m1  = (div == '0) ? '0 : div - 1'b1;
  assign at_samp = (cnt == samp);
  assign at_end  = (cnt >= div_m1);
  assign last    = 3'd4 + {1'b0, len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; cnt <= '0; idx <= '0; dat <= '0; line_q <= 1'b1;
      acc <= 1'b0; perr <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_perr <= 1'b0; out_serr <= 1'b0;
    end else begin
      line_q    <= line;
      out_valid <= 1'b0;
      if (!run) begin
        st  <= R_IDLE;
        cnt <= '0;
      end else if (st == R_IDLE) begin
        cnt <= '0;
        if (line_q && !line) begin
          st <= R_START; dat <= '0; acc <= 1'b0; perr <= 1'b0; idx <= '0;
        end
      end else begin
        cnt <= at_end ? '0 : cnt + 1'b1;
        case (st)
          R_START: begin
            if (at_samp && line) st <= R_IDLE;
            else if (at_end)     st <= R_DATA;
          end
          R_DATA: begin
            if (at_samp) begin
              dat[idx] <= line;
              acc      <= acc ^ line;
            end
            if (at_end) begin
              if (idx == last) st <= par_en ? R_PAR : R_STOP;
              else             idx <= idx + 3'd1;
            end
          end
          R_PAR: begin
            if (at_samp) perr <= (line != (par_even ? acc : !acc));
            if (at_end)  st <= R_STOP;
          end
          R_STOP: begin
            if (at_samp) begin
              out_valid <= 1'b1;
              out_data  <= dat;
              out_perr  <= perr;
              out_serr  <= !line;
              st        <= R_IDLE;
            end
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && st == R_START && at_samp && line) |=> (st == R_IDLE)); // R7
  AST_DELIVER_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(st) == R_STOP)); // R6
endmodule

// File: rtl/cfg_uart.sv
module cfg_uart
  import cfg_uart_pkg::*;
#(
  parameter int DIV_W  = 24,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  logic [31:0]       cfg_q;
  logic [DIV_W-1:0]  samp_q;
  logic [N_INT-1:0]  ien_q, ista;
  logic [N_EV-1:0]   lat_q, ev, clr_mask;
  logic              rs1, rs2;
  logic              wr, rd, tx_wr, rx_rd, clr_wr;
  logic              txf_in_ready, txf_ov, txf_full, txf_empty, tx_ready;
  logic [DATA_W-1:0] txf_data;
  logic              rxu_v, rxu_perr, rxu_serr;
  logic [DATA_W-1:0] rxu_data, rxf_data;
  logic              rxf_in_ready, rxf_ov, rxf_full, rxf_empty;

  assign wr     = bus_sel && bus_we;
  assign rd     = bus_sel && !bus_we;
  assign tx_wr  = wr && (bus_addr == W_TXD);
  assign rx_rd  = rd && (bus_addr == W_RXD);
  assign clr_wr = wr && (bus_addr == W_ICLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      samp_q <= DIV_W'(7);
      ien_q  <= '0;
    end else if (wr) begin
      if (bus_addr == W_CFG)  cfg_q  <= bus_wdata;
      if (bus_addr == W_SAMP) samp_q <= bus_wdata[DIV_W-1:0];
      if (bus_addr == W_IEN)  ien_q  <= bus_wdata[N_INT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b1;
      rs2 <= 1'b1;
    end else begin
      rs1 <= rxd;
      rs2 <= rs1;
    end
  end

  cfg_uart_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_wr), .in_ready(txf_in_ready), .in_data(bus_wdata[DATA_W-1:0]),
    .out_valid(txf_ov), .out_ready(tx_ready), .out_data(txf_data),
    .full(txf_full), .empty(txf_empty));

  cfg_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .run(cfg_q[7] && cfg_q[5]),
    .div(cfg_q[8 +: DIV_W]), .len(cfg_q[1:0]), .par_en(cfg_q[4]),
    .par_even(cfg_q[3]), .two_stop(cfg_q[2]),
    .in_valid(txf_ov), .in_ready(tx_ready), .in_data(txf_data), .txd(txd));

  cfg_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .run(cfg_q[7] && cfg_q[6]), .line(rs2),
    .div(cfg_q[8 +: DIV_W]), .samp(samp_q), .len(cfg_q[1:0]),
    .par_en(cfg_q[4]), .par_even(cfg_q[3]),
    .out_valid(rxu_v), .out_data(rxu_data), .out_perr(rxu_perr), .out_serr(rxu_serr));

  cfg_uart_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rxu_v), .in_ready(rxf_in_ready), .in_data(rxu_data),
    .out_valid(rxf_ov), .out_ready(rx_rd), .out_data(rxf_data),
    .full(rxf_full), .empty(rxf_empty));

  always_comb begin
    ev           = '0;
    ev[EV_TXOVR] = tx_wr && !txf_in_ready;
    ev[EV_SERR]  = rxu_v && rxu_serr;
    ev[EV_PERR]  = rxu_v && rxu_perr;
    ev[EV_RXOVR] = rxu_v && !rxf_in_ready;
    ev[EV_RXUND] = rx_rd && !rxf_ov;
  end

  assign clr_mask = clr_wr ? bus_wdata[N_EV-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~clr_mask) | ev;
  end

  assign ista = {!rxf_empty, txf_empty, lat_q};
  assign irq  = |(ista & ien_q);

  always_comb begin
    case (bus_addr)
      W_CFG:  bus_rdata = cfg_q;
      W_SAMP: bus_rdata = 32'(samp_q);
      W_RXD:  bus_rdata = rxf_ov ? 32'(rxf_data) : 32'd0;
      W_STAT: bus_rdata = {28'd0, txf_empty, txf_full, rxf_empty, rxf_full};
      W_IEN:  bus_rdata = 32'(ien_q);
      W_ICLR: bus_rdata = 32'(lat_q);
      W_ISTA: bus_rdata = 32'(ista);
      default: bus_rdata = 32'd0;
    endcase
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[EV_TXOVR] && !ev[EV_TXOVR]) |=> !lat_q[EV_TXOVR]); // R12
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R12
  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rxf_empty) |=> lat_q[EV_RXUND]); // R11
endmodule

// File: tb/sim_cfg_uart.sv
module sim_cfg_uart;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq, rxd;
  logic        loop = 1'b1, man_rxd = 1'b1;

  assign rxd = loop ? txd : man_rxd;

  cfg_uart u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0;
  bit done = 0;
  localparam int DIV = 16;
  int b_nbits = 8;
  bit b_pen = 0;

  logic [7:0] mon_data [256];
  bit         mon_par  [256];
  bit         mon_stop [256];
  int         mon_sp   [256];
  int         mon_n = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic setcfg(input int len, input bit pen, input bit psel, input bit two, input logic [7:0] enb);
    b_nbits = 5 + len;
    b_pen = pen;
    wr(4'd0, (32'(DIV) << 8) | 32'(enb) | (32'(pen) << 4) | (32'(psel) << 3) | (32'(two) << 2) | 32'(len));
  endtask

  task automatic wait_mon(input int n);
    for (int i = 0; i < 20000 && mon_n < n; i++) @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic drive_bit(input bit v);
    @(negedge clk); man_rxd = v;
    repeat (DIV - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pen, input bit pbit, input bit stopv);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pen) drive_bit(pbit);
    drive_bit(stopv);
    @(negedge clk); man_rxd = 1'b1;
    idle(3 * DIV);
  endtask

  // independent mid-bit decoder of txd
  initial begin
    logic prev;
    logic [7:0] d;
    int last_start, st_c;
    prev = 1'b1;
    last_start = 0;
    forever begin
      @(posedge clk); #1;
      if (prev && !txd) begin
        st_c = cyc;
        d = '0;
        repeat (DIV / 2) @(posedge clk);
        #1;
        for (int i = 0; i < b_nbits; i++) begin
          repeat (DIV) @(posedge clk);
          #1 d[i] = txd;
        end
        if (b_pen) begin
          repeat (DIV) @(posedge clk);
          #1 mon_par[mon_n[7:0]] = txd;
        end
        repeat (DIV) @(posedge clk);
        #1;
        mon_stop[mon_n[7:0]] = txd;
        mon_data[mon_n[7:0]] = d;
        mon_sp[mon_n[7:0]] = st_c - last_start;
        last_start = st_c;
        mon_n++;
        prev = 1'b1;
      end else begin
        prev = txd;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0] ch, mask, exp_ch;
    logic [7:0] q [16];
    int base, cidx, F;
    bit epar;

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    #1;
    chk(txd == 1'b1, "R1 txd idle", 32'(txd), 1);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    rd(4'd6, r);  chk(r == 32'h0A, "R1 queue status", r, 32'h0A);
    rd(4'd11, r); chk(r == 32'h20, "R1 int status", r, 32'h20);

    wr(4'd2, 32'd8);

    // R5 transmit held while global enable clear
    setcfg(3, 0, 0, 0, 8'h60);
    base = mon_n;
    wr(4'd4, 32'h5A);
    idle(20 * DIV);
    chk(mon_n == base, "R5 no tx without global enable", 32'(mon_n), 32'(base));
    rd(4'd6, r); chk(r[3] == 1'b0, "R5 char held in tx queue", r, 32'h02);
    // transmit enable clear
    setcfg(3, 0, 0, 0, 8'hC0);
    idle(20 * DIV);
    chk(mon_n == base, "R5 no tx without tx enable", 32'(mon_n), 32'(base));
    // receiver disabled while transmitting
    setcfg(3, 0, 0, 0, 8'hA0);
    wait_mon(base + 1); idle(60);
    chk(mon_n == base + 1 && mon_data[base[7:0]] == 8'h5A, "R5 sent once enabled",
        32'(mon_data[base[7:0]]), 32'h5A);
    rd(4'd6, r); chk(r[1] == 1'b1, "R5 rx ignored when disabled", r, 32'h0A);

    // sweep of all frame formats via loopback
    cidx = 0;
    for (int len = 0; len < 4; len++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int two = 0; two < 2; two++) begin
          setcfg(len, pm != 0, pm == 2, two[0], 8'hE0);
          mask = 8'hFF >> (8 - (5 + len));
          F = 1 + (5 + len) + (pm != 0 ? 1 : 0) + 1 + two;
          base = mon_n;
          for (int k = 0; k < 3; k++) begin
            ch = 8'(k * 53 + cidx * 29 + 8'h5A);
            wr(4'd4, 32'(ch));
          end
          wait_mon(base + 3); idle(60);
          chk(mon_n == base + 3, "R2 frame count", 32'(mon_n - base), 3);
          for (int k = 0; k < 3; k++) begin
            ch = 8'(k * 53 + cidx * 29 + 8'h5A);
            exp_ch = ch & mask;
            chk(mon_data[8'(base + k)] == exp_ch, "R2 data bits LSB first",
                32'(mon_data[8'(base + k)]), 32'(exp_ch));
            if (pm != 0) begin
              epar = (pm == 2) ? ^exp_ch : ~^exp_ch;
              chk(mon_par[8'(base + k)] == epar, "R3 parity bit", 32'(mon_par[8'(base + k)]), 32'(epar));
            end
            chk(mon_stop[8'(base + k)] == 1'b1, "R4 stop level", 32'(mon_stop[8'(base + k)]), 1);
            if (k > 0)
              chk(mon_sp[8'(base + k)] >= F * DIV && mon_sp[8'(base + k)] <= F * DIV + 2,
                  "R4 frame spacing", 32'(mon_sp[8'(base + k)]), 32'(F * DIV));
          end
          rd(4'd11, r);
          chk(r[6] == 1'b1 && r[2:1] == 2'b00, "R13 rx non-empty, no errors", r, 32'h60);
          for (int k = 0; k < 3; k++) begin
            ch = 8'(k * 53 + cidx * 29 + 8'h5A);
            rd(4'd5, r);
            chk(r == 32'(ch & mask), "R6 received char", r, 32'(ch & mask));
          end
          rd(4'd11, r);
          chk(r[6] == 1'b0, "R13 rx non-empty drops", r, 32'h20);
          cidx++;
        end
      end
    end

    // R9 transmit queue full and overrun
    setcfg(3, 0, 0, 0, 8'hC0);
    wr(4'd9, 32'h1F);
    for (int i = 0; i < 16; i++) begin
      q[i] = 8'(i * 17 + 3);
      wr(4'd4, 32'(q[i]));
    end
    rd(4'd6, r); chk(r[3:2] == 2'b01, "R9 tx full flag", r, 32'h06);
    rd(4'd11, r); chk(r[0] == 1'b0, "R9 no overrun yet", r, 0);
    wr(4'd4, 32'hAB);
    rd(4'd11, r); chk(r[0] == 1'b1, "R9 tx overrun latched", r, 1);
    wr(4'd9, 32'h01);
    rd(4'd11, r); chk(r[0] == 1'b0, "R12 clear by write 1", r, 0);
    rd(4'd11, r); chk(r[5] == 1'b0, "R13 tx empty low while queued", r, 0);
    wr(4'd9, 32'h60);
    rd(4'd11, r); chk(r[5] == 1'b0, "R13 live bits unaffected by clear", r, 0);
    base = mon_n;
    setcfg(3, 0, 0, 0, 8'hE0);
    wait_mon(base + 16); idle(60);
    chk(mon_n == base + 16, "R9 dropped write not sent", 32'(mon_n - base), 16);
    rd(4'd6, r); chk(r[1:0] == 2'b01 && r[3] == 1'b1, "R9 rx full flag", r, 32'h09);
    // R10 receive overrun
    wr(4'd4, 32'hEE);
    wait_mon(base + 17); idle(60);
    rd(4'd11, r); chk(r[3] == 1'b1, "R10 rx overrun latched", r, 32'h08);
    for (int i = 0; i < 16; i++) begin
      rd(4'd5, r);
      chk(r == 32'(q[i]), "R9 rx queue order", r, 32'(q[i]));
    end
    // R11 underrun
    rd(4'd5, r); chk(r == 32'd0, "R11 empty read returns 0", r, 0);
    rd(4'd11, r); chk(r[4] == 1'b1, "R11 underrun latched", r, 32'h10);
    rd(4'd6, r); chk(r[1] == 1'b1, "R9 rx empty after drain", r, 32'h0A);

    // R12 interrupt masking
    wr(4'd7, 32'h10); idle(1); #1;
    chk(irq == 1'b1, "R12 irq from enabled underrun", 32'(irq), 1);
    wr(4'd9, 32'h10); idle(1); #1;
    chk(irq == 1'b0, "R12 irq after clear", 32'(irq), 0);
    wr(4'd9, 32'h1F);
    wr(4'd7, 32'h40); idle(1); #1;
    chk(irq == 1'b0, "R12 rx non-empty masked source idle", 32'(irq), 0);
    base = mon_n;
    wr(4'd4, 32'h33);
    wait_mon(base + 1); idle(60); #1;
    chk(irq == 1'b1, "R13 irq on rx data", 32'(irq), 1);
    rd(4'd5, r); idle(1); #1;
    chk(irq == 1'b0 && r == 32'h33, "R13 irq drops after read", 32'(irq), 0);
    wr(4'd7, 32'h20); idle(1); #1;
    chk(irq == 1'b1, "R12 irq from tx empty", 32'(irq), 1);
    wr(4'd7, 32'h00);

    // R7 glitch rejection
    loop = 1'b0;
    idle(4);
    @(negedge clk); man_rxd = 1'b0;
    repeat (3) @(negedge clk);
    man_rxd = 1'b1;
    idle(4 * DIV);
    rd(4'd6, r); chk(r[1] == 1'b1, "R7 glitch stores nothing", r, 32'h0A);

    // R8 parity error, character kept
    setcfg(3, 1, 1, 0, 8'hE0);
    wr(4'd9, 32'h1F);
    send_frame(8'h01, 1, 1'b0, 1'b1);
    rd(4'd11, r); chk(r[2:1] == 2'b10, "R8 parity error latched", r, 32'h04);
    rd(4'd5, r);  chk(r == 32'h01, "R8 char kept on parity error", r, 32'h01);
    // R6 hand-driven frame with correct parity
    wr(4'd9, 32'h1F);
    send_frame(8'hC3, 1, 1'b0, 1'b1);
    rd(4'd11, r); chk(r[2:1] == 2'b00, "R8 good parity no error", r, 0);
    rd(4'd5, r);  chk(r == 32'hC3, "R6 hand-driven char", r, 32'hC3);
    // R8 stop error
    send_frame(8'h3C, 1, 1'b0, 1'b0);
    rd(4'd11, r); chk(r[1] == 1'b1, "R8 stop error latched", r, 32'h02);
    rd(4'd5, r);  chk(r == 32'h3C, "R8 char kept on stop error", r, 32'h3C);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule